// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Lookup

This block holds the tag and line-state bookkeeping of a four-way set-associative, write-back cache with a 24-bit byte address. The address splits into a 12-bit tag in bits 23..12, an 8-bit set number in bits 11..4 and a 4-bit byte offset in bits 3..0, which the block ignores. Each of the 256 sets keeps four ways. Each way has a stored tag, a valid flag and a dirty flag, and each set has a 2-bit rotation pointer. Line data and the path to main memory belong to other blocks.

A controller issues one command at a time through a valid/ready pair. A lookup (read or write) compares the request tag with all four ways of the addressed set at once. The response gives either a hit and the matching way, or a miss with a proposed victim way and a flag that says whether the victim must be written back first. The victim is the lowest-numbered invalid way if there is one. If every way is valid, it is the lowest-numbered clean way. If all four ways are dirty, the set's rotation pointer picks the victim and then moves on. Update commands load a tag into a way (fill), mark a way clean after its writeback, or invalidate a way.

Control is a three-state machine. ST_IDLE accepts a command. A read or write moves it to ST_LOOKUP, and a fill, clean or invalidate moves it to ST_UPDATE. Both of those states return to ST_IDLE after one cycle.

Top module: `setassoc_tag_lookup`

## Requirements
- R1: The stored tag is address bits 23..12 and the set is bits 11..4. Bits 3..0 have no effect. Addresses 0xAB7129, 0x895123, 0xCD4128 and 0x543126 all fall in set 0x12, with tags 0xAB7, 0x895, 0xCD4 and 0x543. Sets are independent of each other.
- R2: A lookup hits when a valid way in the addressed set holds the request tag. The response then shows rsp_hit=1 and that way on rsp_way, with rsp_wb_needed=0.
- R3: An invalid way never hits, even if its stored tag equals the request tag.
- R4: On a miss, if any way is invalid, the victim is the lowest-numbered invalid way and rsp_wb_needed=0.
- R5: On a miss where all ways are valid and at least one is clean, the victim is the lowest-numbered clean way and rsp_wb_needed=0.
- R6: On a miss where all four ways are valid and dirty, the victim is the set's rotation pointer and rsp_wb_needed=1. The pointer then advances by one, wrapping from 3 to 0. Other misses leave it unchanged.
- R7: Fill (req_op=2) stores the tag of req_addr in way req_way and makes that way valid and clean.
- R8: A write lookup (req_op=1) that hits marks the hit way dirty. A read lookup (req_op=0) changes no state.
- R9: Clean (req_op=3) clears the dirty flag of way req_way. Invalidate (req_op=4) clears both its valid and dirty flags.
- R10: A command is accepted when req_valid and req_ready are both high. req_ready is low in the next cycle. A lookup gives a one-cycle rsp_valid pulse two clock edges after the accepting edge. Update commands give no response.
- R11: Reset clears every valid flag, dirty flag and rotation pointer. After reset, req_ready=1 and rsp_valid=0.
- R12: While rsp_valid is low, rsp_hit, rsp_way, rsp_victim and rsp_wb_needed are all 0. On a hit, rsp_victim is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block can accept a command |
| req_op | input | 3 | 0 read, 1 write, 2 fill, 3 clean, 4 invalidate |
| req_addr | input | 24 | Byte address giving tag and set |
| req_way | input | 2 | Target way for update commands |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found the tag |
| rsp_way | output | 2 | Matching way on a hit |
| rsp_victim | output | 2 | Proposed replacement way on a miss |
| rsp_wb_needed | output | 1 | Victim is dirty and must be written back first |

## Verification
A wrong valid flag appears as a false or missing hit, or as a shifted victim, on the very next lookup of that set. A stray or missing dirty flag shows up only once the set is full: it changes which clean way is picked or raises rsp_wb_needed too early or too late. A wrong rotation pointer shows only when every way is dirty, as a victim sequence that departs from 0,1,2,3,0. The bench therefore fills one set completely, dirties it step by step, and probes it with misses after each state change, so that every corrupted flag is visible within one lookup.

// File: rtl/tagl_pkg.sv
package tagl_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_FILL  = 3'd2,
        OP_CLEAN = 3'd3,
        OP_INVAL = 3'd4
    } tl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_UPDATE = 2'd2
    } tl_state_e;

endpackage

// File: rtl/tagl_store.sv
module tagl_store #(
    parameter int SET_W = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SETS  = 1 << SET_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAY_W-1:0]            rd_rr,
    input  logic                        upd_en,
    input  logic [SET_W-1:0]            upd_set,
    input  logic [WAYS-1:0]             upd_mask,
    input  logic [TAG_W-1:0]            upd_tag,
    input  logic                        upd_tag_we,
    input  logic                        upd_valid_set,
    input  logic                        upd_valid_clr,
    input  logic                        upd_dirty_set,
    input  logic                        upd_dirty_clr,
    input  logic                        upd_rr_adv
);

    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [WAY_W-1:0]           rr_q    [SETS];

    assign rd_tags  = tag_q[rd_set];
    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_rr    = rr_q[rd_set];

    // Tag storage needs no reset: a way's tag only counts once it is valid.
    always_ff @(posedge clk) begin
        if (upd_en && upd_tag_we) begin
            for (int w = 0; w < WAYS; w++) begin
                if (upd_mask[w]) begin
                    tag_q[upd_set][w] <= upd_tag;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else if (upd_en) begin
            valid_q[upd_set] <= (valid_q[upd_set] | (upd_valid_set ? upd_mask : '0))
                                & ~(upd_valid_clr ? upd_mask : '0);
            dirty_q[upd_set] <= (dirty_q[upd_set] | (upd_dirty_set ? upd_mask : '0))
                                & ~(upd_dirty_clr ? upd_mask : '0);
            if (upd_rr_adv) begin
                rr_q[upd_set] <= rr_q[upd_set] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tagl_compare.sv
module tagl_compare #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = way_valid[w] && (way_tags[w] == req_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tagl_victim.sv
module tagl_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAYS-1:0]  way_dirty,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             wb_needed,
    output logic             use_rr
);

    logic [WAYS-1:0]  free_ways;
    logic [WAYS-1:0]  clean_ways;
    logic [WAY_W-1:0] low_free;
    logic [WAY_W-1:0] low_clean;

    assign free_ways  = ~way_valid;
    assign clean_ways = way_valid & ~way_dirty;

    always_comb begin
        low_free  = '0;
        low_clean = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (free_ways[w])  low_free  = WAY_W'(w);
            if (clean_ways[w]) low_clean = WAY_W'(w);
        end
    end

    always_comb begin
        use_rr    = 1'b0;
        wb_needed = 1'b0;
        if (|free_ways) begin
            victim = low_free;
        end else if (|clean_ways) begin
            victim = low_clean;
        end else begin
            victim    = rr_ptr;
            use_rr    = 1'b1;
            wb_needed = 1'b1;
        end
    end

endmodule

// File: rtl/setassoc_tag_lookup.sv
module setassoc_tag_lookup
    import tagl_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 8,
    parameter int WAYS   = 4,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WAY_W-1:0]  req_way,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [WAY_W-1:0]  rsp_victim,
    output logic              rsp_wb_needed
);

    tl_state_e state_q, state_d;

    tl_op_e           op_q;
    logic [SET_W-1:0] set_q;
    logic [TAG_W-1:0] tag_q;
    logic [WAY_W-1:0] way_q;

    logic [OFF_W-1:0] unused_offset;
    assign unused_offset = req_addr[OFF_W-1:0];

    logic accept;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Stored view of the addressed set
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0]            set_dirty;
    logic [WAY_W-1:0]           set_rr;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic             wb_needed;
    logic             use_rr;

    // Store update controls
    logic            upd_en;
    logic [WAYS-1:0] upd_mask;
    logic            upd_tag_we;
    logic            upd_valid_set;
    logic            upd_valid_clr;
    logic            upd_dirty_set;
    logic            upd_dirty_clr;
    logic            upd_rr_adv;

    tagl_store #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W)) store_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_set        (set_q),
        .rd_tags       (set_tags),
        .rd_valid      (set_valid),
        .rd_dirty      (set_dirty),
        .rd_rr         (set_rr),
        .upd_en        (upd_en),
        .upd_set       (set_q),
        .upd_mask      (upd_mask),
        .upd_tag       (tag_q),
        .upd_tag_we    (upd_tag_we),
        .upd_valid_set (upd_valid_set),
        .upd_valid_clr (upd_valid_clr),
        .upd_dirty_set (upd_dirty_set),
        .upd_dirty_clr (upd_dirty_clr),
        .upd_rr_adv    (upd_rr_adv)
    );

    tagl_compare #(.WAYS(WAYS), .TAG_W(TAG_W)) cmp_i (
        .way_tags  (set_tags),
        .way_valid (set_valid),
        .req_tag   (tag_q),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    tagl_victim #(.WAYS(WAYS)) vic_i (
        .way_valid (set_valid),
        .way_dirty (set_dirty),
        .rr_ptr    (set_rr),
        .victim    (victim),
        .wb_needed (wb_needed),
        .use_rr    (use_rr)
    );

    // Command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_READ;
            set_q <= '0;
            tag_q <= '0;
            way_q <= '0;
        end else if (accept) begin
            op_q  <= tl_op_e'(req_op);
            set_q <= req_addr[OFF_W +: SET_W];
            tag_q <= req_addr[OFF_W + SET_W +: TAG_W];
            way_q <= req_way;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_op == OP_READ || req_op == OP_WRITE) state_d = ST_LOOKUP;
                    else                                         state_d = ST_UPDATE;
                end
            end
            ST_LOOKUP: state_d = ST_IDLE;
            ST_UPDATE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Store write controls per state
    always_comb begin
        upd_en        = 1'b0;
        upd_mask      = '0;
        upd_tag_we    = 1'b0;
        upd_valid_set = 1'b0;
        upd_valid_clr = 1'b0;
        upd_dirty_set = 1'b0;
        upd_dirty_clr = 1'b0;
        upd_rr_adv    = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                upd_en = 1'b1;
                if (hit) begin
                    upd_mask      = WAYS'(1) << hit_way;
                    upd_dirty_set = (op_q == OP_WRITE);
                end else begin
                    upd_rr_adv = use_rr;
                end
            end
            ST_UPDATE: begin
                upd_en   = 1'b1;
                upd_mask = WAYS'(1) << way_q;
                unique case (op_q)
                    OP_FILL: begin
                        upd_tag_we    = 1'b1;
                        upd_valid_set = 1'b1;
                        upd_dirty_clr = 1'b1;
                    end
                    OP_CLEAN: upd_dirty_clr = 1'b1;
                    OP_INVAL: begin
                        upd_valid_clr = 1'b1;
                        upd_dirty_clr = 1'b1;
                    end
                    default: upd_en = 1'b0;
                endcase
            end
            default: ;
        endcase
    end

    // Registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_way       <= '0;
            rsp_victim    <= '0;
            rsp_wb_needed <= 1'b0;
        end else begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_way       <= '0;
            rsp_victim    <= '0;
            rsp_wb_needed <= 1'b0;
            if (state_q == ST_LOOKUP) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= hit;
                if (hit) begin
                    rsp_way <= hit_way;
                end else begin
                    rsp_victim    <= victim;
                    rsp_wb_needed <= wb_needed;
                end
            end
        end
    end

endmodule

// File: rtl/tagl_checker.sv
module tagl_checker #(
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic [WAY_W-1:0] rsp_victim,
    input logic             rsp_wb_needed
);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_lookup_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd0 || req_op == 3'd1)) |=> ##1 rsp_valid);

    p_update_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op >= 3'd2) |=> ##1 !rsp_valid);

    p_hit_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && !rsp_wb_needed && rsp_victim == '0));

    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_way == '0 && rsp_victim == '0 && !rsp_wb_needed));

endmodule

bind setassoc_tag_lookup tagl_checker #(.WAY_W(WAY_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_way       (rsp_way),
    .rsp_victim    (rsp_victim),
    .rsp_wb_needed (rsp_wb_needed)
);

// File: tb/setassoc_tag_lookup_tb_top.sv
`timescale 1ns/1ps
module setassoc_tag_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_way = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_way;
    logic [1:0]  rsp_victim;
    logic        rsp_wb_needed;

    always #10 clk = ~clk;

    setassoc_tag_lookup dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_way       (req_way),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_way       (rsp_way),
        .rsp_victim    (rsp_victim),
        .rsp_wb_needed (rsp_wb_needed)
    );

    typedef struct {
        logic       hit;
        logic [1:0] way;
        logic [1:0] vic;
        logic       wb;
        int         cyc;
        string      rq;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    int   quiet_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", rq, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [23:0] addr, input logic [1:0] way, output int stamp);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_way   = way;
        stamp     = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic lookup(input logic wr, input logic [23:0] addr, input logic hit, input logic [1:0] way,
                          input logic [1:0] vic, input logic wb, input string rq);
        exp_t e;
        int   st;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.hit = hit; e.way = way; e.vic = vic; e.wb = wb; e.rq = rq;
        e.cyc = cyc + 2;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_op    = wr ? 3'd1 : 3'd0;
        req_addr  = addr;
        req_way   = 2'd0;
        st        = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic update(input logic [2:0] op, input logic [23:0] addr, input logic [1:0] way);
        int st;
        send(op, addr, way, st);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", "rsp_valid=1", "no response");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.cyc, "R10", "response cycle",
                      $sformatf("%0d", cyc), $sformatf("%0d", e.cyc));
                check(rsp_hit == e.hit && (!e.hit || rsp_way == e.way) &&
                      (e.hit || rsp_victim == e.vic) && rsp_wb_needed == e.wb, e.rq, "lookup result",
                      $sformatf("hit=%0d way=%0d vic=%0d wb=%0d", rsp_hit, rsp_way, rsp_victim, rsp_wb_needed),
                      $sformatf("hit=%0d way=%0d vic=%0d wb=%0d", e.hit, e.way, e.vic, e.wb));
            end
        end else if (!rsp_valid && (rsp_hit || rsp_way != 0 || rsp_victim != 0 || rsp_wb_needed)) begin
            quiet_bad++;
        end
    end

    localparam int OP_FILL  = 2;
    localparam int OP_CLEAN = 3;
    localparam int OP_INVAL = 4;

    initial begin : main
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R11 reset state
                check(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "reset outputs",
                      $sformatf("ready=%0d valid=%0d", req_ready, rsp_valid), "ready=1 valid=0");

                // R4 empty set
                lookup(0, 24'hAB7129, 0, 0, 2'd0, 0, "R4");
                // R7 fill way0; R1 offset ignored
                update(3'(OP_FILL), 24'hAB7120, 2'd0);
                lookup(0, 24'hAB7123, 1, 2'd0, 0, 0, "R1");
                lookup(0, 24'h895123, 0, 0, 2'd1, 0, "R4");
                update(3'(OP_FILL), 24'hCD4128, 2'd2);
                lookup(0, 24'h895123, 0, 0, 2'd1, 0, "R4");
                lookup(0, 24'hCD4120, 1, 2'd2, 0, 0, "R2");
                update(3'(OP_FILL), 24'h895123, 2'd1);
                update(3'(OP_FILL), 24'h543126, 2'd3);
                lookup(0, 24'h543126, 1, 2'd3, 0, 0, "R7");
                lookup(0, 24'h89512F, 1, 2'd1, 0, 0, "R2");
                // R1 different set is empty
                lookup(0, 24'hAB7139, 0, 0, 2'd0, 0, "R1");
                // R5 full and clean
                lookup(0, 24'h111120, 0, 0, 2'd0, 0, "R5");
                // R8 write hits dirty ways 0 and 2
                lookup(1, 24'hAB712C, 1, 2'd0, 0, 0, "R8");
                lookup(1, 24'hCD4121, 1, 2'd2, 0, 0, "R8");
                lookup(0, 24'h111120, 0, 0, 2'd1, 0, "R5");
                lookup(0, 24'h895120, 1, 2'd1, 0, 0, "R8");
                lookup(0, 24'h111120, 0, 0, 2'd1, 0, "R8");
                lookup(1, 24'h895124, 1, 2'd1, 0, 0, "R8");
                lookup(0, 24'h111120, 0, 0, 2'd3, 0, "R5");
                lookup(1, 24'h543127, 1, 2'd3, 0, 0, "R8");
                // R6 all dirty: rotation 0,1,2,3,0
                lookup(0, 24'h111120, 0, 0, 2'd0, 1, "R6");
                lookup(1, 24'h222120, 0, 0, 2'd1, 1, "R6");
                lookup(0, 24'h333120, 0, 0, 2'd2, 1, "R6");
                lookup(0, 24'h111120, 0, 0, 2'd3, 1, "R6");
                lookup(0, 24'h111120, 0, 0, 2'd0, 1, "R6");
                // R6 hits leave pointer alone
                lookup(0, 24'hAB7120, 1, 2'd0, 0, 0, "R2");
                lookup(0, 24'h111120, 0, 0, 2'd1, 1, "R6");
                // R9 clean way2
                update(3'(OP_CLEAN), 24'hCD4120, 2'd2);
                lookup(0, 24'h111120, 0, 0, 2'd2, 0, "R9");
                // R9 invalidate way1; R3 stale tag does not hit
                update(3'(OP_INVAL), 24'h895120, 2'd1);
                lookup(0, 24'h895123, 0, 0, 2'd1, 0, "R3");
                // R9 refill way1 is clean: still lowest clean is 1
                update(3'(OP_FILL), 24'h895123, 2'd1);
                lookup(0, 24'h111120, 0, 0, 2'd1, 0, "R9");
                drain();

                // R11 reset mid-run clears all state
                @(negedge clk);
                rst_n = 1'b0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                check(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "ready after reset",
                      $sformatf("ready=%0d valid=%0d", req_ready, rsp_valid), "ready=1 valid=0");
                lookup(0, 24'hAB7129, 0, 0, 2'd0, 0, "R11");
                drain();

                check(quiet_bad == 0, "R12", "outputs quiet without rsp_valid",
                      $sformatf("%0d bad cycles", quiet_bad), "0 bad cycles");
                check(exp_q.size() == 0, "R10", "all responses seen",
                      $sformatf("%0d pending", exp_q.size()), "0 pending");
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "R10", "watchdog", "timeout", "completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule